// File: doc/BRIEF.md
# DDR Pre-emphasis Serializer

This block turns one 30-bit parallel word per word-clock cycle into a double-data-rate serial stream. The word arrives already line-coded. The word clock is slow. A fast clock runs at exactly 15 times the word rate and is phase-locked to the word clock. Bits at even positions are moved into one 15-bit shift register, which advances on the rising fast edge. Bits at odd positions are moved into a second 15-bit register, which advances on the falling fast edge. The fast clock level then selects which register drives the line, so each fast period carries two bits. All 30 bits go out in one word period.

A second output carries the same stream one bit period later, which is half a fast period. A pre-emphasis driver uses it. A transition flag is high whenever the current bit differs from the bit before it, so the driver can boost that bit. A third-rate mode repeats each of the 10 low input bits three times before serialization. The line rate stays the same, and the effective data rate drops to one third.

The load strobe for the shift registers is created in the fast domain. A synchronizer samples the word clock level, and the strobe is aligned to its rising edge. Both shift registers are held in three copies and each bit is decided by a majority vote, so that a single upset is corrected on the next edge. A sleep input clears and freezes the datapath.

Top module: `ddr_pe_serializer`

## Requirements
- R1: After reset is released and before any word is loaded, `serOut`, `serDly` and `edgeFlag` are all 0.
- R2: A loaded word goes out bit 0 first and then in ascending index order, one bit per half fast period. Even-indexed bits appear while `clkFast` is high and odd-indexed bits appear while it is low.
- R3: A word captured on a rising `clkWord` edge places its bit 0 on `serOut` from the fourth rising `clkFast` edge after that word edge. This holds when the word edge falls strictly between fast edges.
- R4: Words loaded in consecutive word-clock cycles go out back to back, with no gap and no repeated bit. Load strobes are exactly 15 fast cycles apart.
- R5: A word-clock cycle with `loadEn` low loads nothing. Once the previous word has been sent, the stream holds that word's bit 29. After reset this value is 0.
- R6: With `rateThird` high at capture, serial bit k equals `dataIn[k/3]` for k = 0..29, and `dataIn[29:10]` is ignored.
- R7: `serDly` always equals the value `serOut` had one bit period (half a fast period) earlier.
- R8: `edgeFlag` is 1 exactly when the current `serOut` bit differs from the current `serDly` bit.
- R9: While `sleep` is high, `serOut`, `serDly` and `edgeFlag` are 0 and no word is loaded. After `sleep` falls, the outputs stay 0 until a new word is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clkWord | input | 1 | Word-rate clock; parallel word captured on its rising edge |
| clkFast | input | 1 | Bit clock at 15x the word rate, phase-locked to clkWord |
| rstN | input | 1 | Asynchronous active-low reset |
| sleep | input | 1 | High clears the serializer and blocks loads |
| loadEn | input | 1 | Capture and send the word present at this word edge |
| rateThird | input | 1 | High selects the third-rate mode (each of 10 bits sent three times) |
| dataIn | input | 30 | Parallel word, already line-coded, bit 0 sent first |
| serOut | output | 1 | Primary DDR serial stream |
| serDly | output | 1 | Serial stream delayed by one bit period |
| edgeFlag | output | 1 | High when the current bit differs from the previous bit |

## Verification
Each half fast period exposes the lowest bit of one of the two shift registers directly on `serOut`. A wrong shift, a wrong fill or a wrong even/odd split therefore shows up on the line within one bit period of the faulty edge. A load strobe that fires one fast cycle early or late moves the whole word by two bit positions, so it is already visible at the first sampled bit of a word. A wrong hold value only appears in a cycle with no load, after the 30th bit of the previous word. The bench therefore places idle slots after words whose last bit is 1 and after words whose last bit is 0. The delayed stream and the transition flag come from the same two voted bits. Bench checks on `serOut` also cover `serDly` one bit later, and a fault in the selection between the two registers shows on both outputs in the same half period.

// File: rtl/ddrser_pkg.sv
package ddrser_pkg;

  // number of redundant copies of every serializer register
  localparam int unsigned TMR_WAYS = 3;

  // strobes from the control to the datapath
  typedef struct packed {
    logic loadEven;   // load the rising-edge register at the next rising edge
    logic loadOdd;    // load the falling-edge register at the next falling edge
    logic run;        // low clears and freezes the datapath
  } serStrobe_t;

endpackage

// File: rtl/ddrser_ctrl.sv
module ddrser_ctrl
  import ddrser_pkg::*;
#(
  parameter int unsigned HALF_W      = 15,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clkFast,
  input  logic       rstN,
  input  logic       wordClkLvl,
  input  logic       wordValid,
  input  logic       sleep,
  output serStrobe_t strobe
);

  localparam int unsigned GAP_W = $clog2(HALF_W + 1);

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   prevLvl;
  logic                   wordEdge;
  logic                   tickQ;
  logic                   loadEvenQ;
  logic                   loadOddQ;
  logic [GAP_W-1:0]       gapCnt;
  logic                   seenTick;

  // rising edge of the synchronized word clock level
  assign wordEdge = syncQ[SYNC_STAGES-1] & ~prevLvl;

  always_ff @(posedge clkFast or negedge rstN) begin
    if (!rstN) begin
      syncQ     <= '0;
      prevLvl   <= 1'b0;
      tickQ     <= 1'b0;
      loadEvenQ <= 1'b0;
      loadOddQ  <= 1'b0;
    end else begin
      syncQ     <= {syncQ[SYNC_STAGES-2:0], wordClkLvl};
      prevLvl   <= syncQ[SYNC_STAGES-1];
      tickQ     <= wordEdge;
      loadEvenQ <= wordEdge & wordValid & ~sleep;
      // the odd register loads one half period after the even one
      loadOddQ  <= loadEvenQ & ~sleep;
    end
  end

  // distance between word ticks, used only to police alignment
  always_ff @(posedge clkFast or negedge rstN) begin
    if (!rstN) begin
      gapCnt   <= '0;
      seenTick <= 1'b0;
    end else begin
      seenTick <= seenTick | tickQ;
      if (tickQ) begin
        gapCnt <= '0;
      end else if (gapCnt != GAP_W'(HALF_W)) begin
        gapCnt <= gapCnt + 1'b1;
      end
    end
  end

  always_comb begin
    strobe.loadEven = loadEvenQ;
    strobe.loadOdd  = loadOddQ;
    strobe.run      = ~sleep;
  end

  AST_LOAD_SPACING: assert property (@(posedge clkFast) disable iff (!rstN)
    (tickQ && seenTick) |-> (gapCnt == GAP_W'(HALF_W - 1)));  // R4

  AST_SLEEP_NO_LOAD: assert property (@(posedge clkFast) disable iff (!rstN)
    $past(sleep) |-> !strobe.loadEven);  // R9

endmodule

// File: rtl/ddrser_datapath.sv
module ddrser_datapath
  import ddrser_pkg::*;
#(
  parameter int unsigned WORD_W   = 30,
  parameter int unsigned RATE_DIV = 3
) (
  input  logic              clkWord,
  input  logic              clkFast,
  input  logic              rstN,
  input  logic              loadEn,
  input  logic              rateThird,
  input  logic [WORD_W-1:0] dataIn,
  input  serStrobe_t        strobe,
  output logic              wordValid,
  output logic              serOut,
  output logic              serDly,
  output logic              edgeFlag
);

  localparam int unsigned HALF_W = WORD_W / 2;

  logic [WORD_W-1:0] tripled;
  logic [WORD_W-1:0] wordReg;
  logic              wordThird;
  logic [HALF_W-1:0] evenLoad;
  logic [HALF_W-1:0] oddLoad;
  logic [HALF_W-1:0] evenNext;
  logic [HALF_W-1:0] oddNext;
  logic [HALF_W-1:0] evenVote;
  logic [HALF_W-1:0] oddVote;
  logic              evenBit;
  logic              oddBit;

  // third-rate expansion: every low input bit fills RATE_DIV slots
  for (genvar i = 0; i < WORD_W; i++) begin : gTriple
    assign tripled[i] = dataIn[i / RATE_DIV];
  end

  // word-clock capture
  always_ff @(posedge clkWord or negedge rstN) begin
    if (!rstN) begin
      wordReg   <= '0;
      wordValid <= 1'b0;
      wordThird <= 1'b0;
    end else begin
      wordValid <= loadEn;
      wordThird <= rateThird;
      if (loadEn) begin
        wordReg <= rateThird ? tripled : dataIn;
      end
    end
  end

  // even/odd split of the captured word
  for (genvar j = 0; j < HALF_W; j++) begin : gSplit
    assign evenLoad[j] = wordReg[2*j];
    assign oddLoad[j]  = wordReg[2*j+1];
  end

  // next state from the voted value; once the data is out, both fill with the last odd bit
  always_comb begin
    if (!strobe.run) begin
      evenNext = '0;
      oddNext  = '0;
    end else begin
      evenNext = strobe.loadEven ? evenLoad : {oddVote[HALF_W-1], evenVote[HALF_W-1:1]};
      oddNext  = strobe.loadOdd  ? oddLoad  : {oddVote[HALF_W-1], oddVote[HALF_W-1:1]};
    end
  end

  // redundant copies: even on the rising edge, odd on the falling edge
  for (genvar c = 0; c < TMR_WAYS; c++) begin : gEvenCopy
    logic [HALF_W-1:0] q;
    always_ff @(posedge clkFast or negedge rstN) begin
      if (!rstN) q <= '0;
      else       q <= evenNext;
    end
  end

  for (genvar c = 0; c < TMR_WAYS; c++) begin : gOddCopy
    logic [HALF_W-1:0] q;
    always_ff @(negedge clkFast or negedge rstN) begin
      if (!rstN) q <= '0;
      else       q <= oddNext;
    end
  end

  // bitwise majority of the three copies
  assign evenVote = (gEvenCopy[0].q & gEvenCopy[1].q) |
                    (gEvenCopy[0].q & gEvenCopy[2].q) |
                    (gEvenCopy[1].q & gEvenCopy[2].q);
  assign oddVote  = (gOddCopy[0].q & gOddCopy[1].q) |
                    (gOddCopy[0].q & gOddCopy[2].q) |
                    (gOddCopy[1].q & gOddCopy[2].q);

  assign evenBit = evenVote[0];
  assign oddBit  = oddVote[0];

  // the clock level picks the live register; the other holds the previous bit
  assign serOut   = clkFast ? evenBit : oddBit;
  assign serDly   = clkFast ? oddBit  : evenBit;
  assign edgeFlag = evenBit ^ oddBit;

  AST_SLEEP_QUIET: assert property (@(posedge clkFast) disable iff (!rstN)
    (!strobe.run && $past(!strobe.run)) |-> (evenVote == '0 && oddVote == '0));  // R9

  AST_RATE_TRIPLE: assert property (@(posedge clkWord) disable iff (!rstN)
    (wordValid && wordThird) |->
      ((&wordReg[RATE_DIV-1:0]) || !(|wordReg[RATE_DIV-1:0])) &&
      ((&wordReg[WORD_W-1:WORD_W-RATE_DIV]) || !(|wordReg[WORD_W-1:WORD_W-RATE_DIV])));  // R6

endmodule

// File: rtl/ddr_pe_serializer.sv
module ddr_pe_serializer
  import ddrser_pkg::*;
#(
  parameter int unsigned WORD_W      = 30,
  parameter int unsigned RATE_DIV    = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clkWord,
  input  logic              clkFast,
  input  logic              rstN,
  input  logic              sleep,
  input  logic              loadEn,
  input  logic              rateThird,
  input  logic [WORD_W-1:0] dataIn,
  output logic              serOut,
  output logic              serDly,
  output logic              edgeFlag
);

  localparam int unsigned HALF_W = WORD_W / 2;

  serStrobe_t strobe;
  logic       wordValid;

  ddrser_ctrl #(
    .HALF_W      (HALF_W),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_ctrl (
    .clkFast    (clkFast),
    .rstN       (rstN),
    .wordClkLvl (clkWord),
    .wordValid  (wordValid),
    .sleep      (sleep),
    .strobe     (strobe)
  );

  ddrser_datapath #(
    .WORD_W   (WORD_W),
    .RATE_DIV (RATE_DIV)
  ) u_dp (
    .clkWord   (clkWord),
    .clkFast   (clkFast),
    .rstN      (rstN),
    .loadEn    (loadEn),
    .rateThird (rateThird),
    .dataIn    (dataIn),
    .strobe    (strobe),
    .wordValid (wordValid),
    .serOut    (serOut),
    .serDly    (serDly),
    .edgeFlag  (edgeFlag)
  );

endmodule

// File: tb/sim_ddr_pe_serializer.sv
`timescale 1ns/100ps
module sim_ddr_pe_serializer;

  localparam int W = 30;

  typedef struct {
    logic  b;
    string tag;
  } item_t;

  logic         clkWord = 1'b0;
  logic         clkFast = 1'b0;
  logic         rstN = 1'b0;
  logic         sleep = 1'b0;
  logic         loadEn = 1'b0;
  logic         rateThird = 1'b0;
  logic [W-1:0] dataIn = '0;
  logic         serOut;
  logic         serDly;
  logic         edgeFlag;

  int    nChecks = 0;
  int    nFail = 0;
  bit    finished = 1'b0;
  item_t expQ[$];
  logic  lastBit = 1'b0;

  ddr_pe_serializer u0 (
    .clkWord   (clkWord),
    .clkFast   (clkFast),
    .rstN      (rstN),
    .sleep     (sleep),
    .loadEn    (loadEn),
    .rateThird (rateThird),
    .dataIn    (dataIn),
    .serOut    (serOut),
    .serDly    (serDly),
    .edgeFlag  (edgeFlag)
  );

  // 250 MHz bit clock, word clock at 1/15 of it with a 1 ns phase offset
  always #2 clkFast = ~clkFast;
  initial begin
    #31 clkWord = 1'b1;
    forever #30 clkWord = ~clkWord;
  end

  task automatic check(input string tag, input string what, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: got %b expected %b at %0t", tag, what, act, exp, $time);
    end
  endtask

  // driver: present a word before a word edge and queue the serial bits it should produce
  task automatic pushWord(input logic le, input logic third, input logic [W-1:0] d, input string tag);
    @(negedge clkWord);
    loadEn    = le;
    rateThird = third;
    dataIn    = d;
    for (int k = 0; k < W; k++) begin
      item_t it;
      if (!le)        it.b = lastBit;
      else if (third) it.b = d[k/3];
      else            it.b = d[k];
      it.tag = (le && k == 0 && tag == "R2") ? "R3" : tag;
      expQ.push_back(it);
    end
    if (le) lastBit = third ? d[9] : d[W-1];
  endtask

  // monitor: bit 0 of the first word is on the line 15 ns after its word edge (R3)
  task automatic runMonitor();
    logic prev;
    prev = 1'b0;
    wait (expQ.size() > 0);
    @(posedge clkWord);
    #16;
    while (expQ.size() > 0) begin
      item_t it;
      it = expQ.pop_front();
      check(it.tag, "serOut", serOut, it.b);
      check("R7", "serDly", serDly, prev);
      check("R8", "edgeFlag", edgeFlag, it.b ^ prev);
      prev = it.b;
      #2;
    end
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  endtask

  initial begin
    #200000;
    nFail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish();
  end

  initial begin
    #21.5 rstN = 1'b1;
    // R1: quiet line before the first load
    repeat (8) begin
      #4;
      check("R1", "serOut", serOut, 1'b0);
      check("R1", "serDly", serDly, 1'b0);
      check("R1", "edgeFlag", edgeFlag, 1'b0);
    end

    fork
      begin
        pushWord(1'b1, 1'b0, 30'h2AAA_AAAA, "R2");
        pushWord(1'b1, 1'b0, 30'h1234_5678, "R4");
        pushWord(1'b1, 1'b0, 30'h3FFF_0001, "R4");
        pushWord(1'b0, 1'b0, 30'h0155_5555, "R5");   // hold 1 (bit 29 of previous)
        pushWord(1'b0, 1'b0, 30'h0000_0000, "R5");
        pushWord(1'b1, 1'b1, 30'h2A5F_F2CE, "R6");   // upper garbage, low 10 bits 10'h2CE
        pushWord(1'b1, 1'b1, 30'h3FFF_FD31, "R6");
        pushWord(1'b1, 1'b0, 30'h0000_0001, "R2");
        pushWord(1'b0, 1'b0, 30'h3FFF_FFFF, "R5");   // hold 0
        pushWord(1'b0, 1'b0, 30'h0000_0000, "R5");
      end
      runMonitor();
    join

    // R9: sleep blocks loads and keeps the line at 0
    @(posedge clkFast);
    #1.5;
    sleep     = 1'b1;
    loadEn    = 1'b1;
    rateThird = 1'b0;
    dataIn    = '1;
    repeat (100) begin
      #2;
      check("R9", "serOut", serOut, 1'b0);
      check("R9", "serDly", serDly, 1'b0);
      check("R9", "edgeFlag", edgeFlag, 1'b0);
    end
    loadEn = 1'b0;
    #120;
    sleep = 1'b0;
    repeat (60) begin
      #2;
      check("R9", "serOut", serOut, 1'b0);
      check("R9", "edgeFlag", edgeFlag, 1'b0);
    end
    finish();
  end

endmodule